// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block provides an eight-byte window of clock and calendar registers at the top of a byte-addressed memory map (default base 0x1FF8 in a 13-bit space). Internally it keeps a chain of BCD counters: second, minute, hour, day of week, date, month and year. Each pulse of a 1 Hz strobe advances the counters, and the cycle after that pulse the whole set is copied, all fields at once, into a visible register copy. Software reads and writes that visible copy over a simple synchronous byte bus.

A control byte at the window base holds two halt bits. The read-halt bit (bit 6) freezes the visible copy so that software can read a consistent time while the counters keep running. The write-halt bit (bit 7) also freezes the copy so that software can load new values. When that bit is cleared, the visible values are moved into the counters in one cycle. The MSB of the seconds byte is a stop bit that gates the 1 Hz strobe. It can be written at any time.

Sequencing is handled by a four-state machine. RUN: copying is enabled. RDHALT: read halt. WRHALT: write halt. XFER: a one-cycle transfer of the visible values into the counters. From RUN or RDHALT, a control write with bit 7 set moves to WRHALT. Otherwise it moves to RDHALT or RUN, following bit 6. From WRHALT, a control write with bit 7 clear moves to XFER. XFER always leaves after one cycle, to RDHALT if the stored bit 6 is set and to RUN if it is not.

Top module: `tk_regbank`

## Requirements
- R1: After reset, the bank reads control 0x00, second 0x00, minute 0x00, hour 0x00, day 0x01, date 0x01, month 0x01 and year 0x00, and the stop bit is clear.
- R2: A read strobe at offset k returns data on bus_rdata one cycle later. The offsets are 0 control, 1 second (bit 7 = stop), 2 minute, 3 hour, 4 day of week, 5 date, 6 month and 7 year. Unused high bits read 0, and an address outside the window reads 0x00.
- R3: Seconds and minutes count 00–59 and hours count 00–23 in BCD, with the ones digit carrying from 9 to the tens digit. The day of week counts 1–7 and wraps to 1 at midnight.
- R4: At midnight the date wraps to 01 after 28 in February of a non-leap year, after 29 in February of a leap year, after 30 in April, June, September and November, and after 31 in every other month. A leap year is a BCD year whose value is divisible by 4.
- R5: After the last day of month 0x12, the month becomes 0x01 and the year advances in BCD. Year 0x99 wraps to 0x00.
- R6: In RUN, every counted tick is followed one cycle later by a copy of all counter fields into the visible registers.
- R7: While control bit 6 is set, the visible registers keep their values and the counters keep counting. After the bit is cleared, the next tick shows the current count.
- R8: A control write that sets bit 6 in the same cycle as a tick does not cancel the copy for that tick.
- R9: While control bit 7 is set, values written to offsets 1–7 stay visible and are not overwritten. Clearing bit 7 loads them into the counters, and counting continues from the loaded values.
- R10: Writing 1 to bit 7 of the seconds byte stops counting without any halt bit. Writing 0 resumes counting on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle strobe once per second |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |

## Verification
The hardest condition to reach is a read-halt request that arrives in the exact cycle of a tick (R8). In that case the copy already scheduled must still take place. The bench drives the tick strobe and the control write on the same falling edge, then reads the seconds byte to confirm that it advanced, and reads it again after another tick to confirm that it is frozen. Month-end and year-end roll-overs are reached without waiting days of ticks: the bench loads a time one second before midnight through the write-halt transfer and then sends a single tick.

// File: rtl/tk_pkg.sv
package tk_pkg;

    typedef enum logic [1:0] {ST_RUN, ST_RDHALT, ST_WRHALT, ST_XFER} tk_state_e;

    typedef struct packed {
        logic [7:0] yr;
        logic [4:0] mon;
        logic [5:0] date;
        logic [2:0] dow;
        logic [5:0] hr;
        logic [6:0] mn;
        logic [6:0] sec;
    } tk_time_t;

    localparam tk_time_t TK_RESET = '{yr: 8'h00, mon: 5'h01, date: 6'h01,
                                      dow: 3'd1, hr: 6'h00, mn: 7'h00, sec: 7'h00};

    // BCD increment of a two-digit value; caller handles the wrap point
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // value = 10*t + u; mod 4 equals (2*t + u) mod 4
    function automatic logic bcd_leap(input logic [7:0] y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        return (s[1:0] == 2'd0);
    endfunction

    function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      return bcd_leap(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/tk_counters.sv
module tk_counters
    import tk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step,
    input  logic     load,
    input  tk_time_t load_val,
    output tk_time_t cnt
);
    tk_time_t   nxt;
    logic [7:0] i_sec, i_mn, i_hr, i_date, i_mon, i_yr;
    logic       c_sec, c_mn, c_hr, c_date, c_mon;

    assign i_sec  = bcd_inc({1'b0, cnt.sec});
    assign i_mn   = bcd_inc({1'b0, cnt.mn});
    assign i_hr   = bcd_inc({2'b0, cnt.hr});
    assign i_date = bcd_inc({2'b0, cnt.date});
    assign i_mon  = bcd_inc({3'b0, cnt.mon});
    assign i_yr   = bcd_inc(cnt.yr);

    always_comb begin
        c_sec  = (cnt.sec == 7'h59);
        c_mn   = c_sec && (cnt.mn == 7'h59);
        c_hr   = c_mn && (cnt.hr == 6'h23);
        c_date = c_hr && (cnt.date == month_last(cnt.mon, cnt.yr));
        c_mon  = c_date && (cnt.mon == 5'h12);

        nxt      = cnt;
        nxt.sec  = c_sec ? 7'h00 : i_sec[6:0];
        if (c_sec) nxt.mn   = (cnt.mn == 7'h59) ? 7'h00 : i_mn[6:0];
        if (c_mn)  nxt.hr   = (cnt.hr == 6'h23) ? 6'h00 : i_hr[5:0];
        if (c_hr)  nxt.dow  = (cnt.dow == 3'd7) ? 3'd1 : cnt.dow + 3'd1;
        if (c_hr)  nxt.date = c_date ? 6'h01 : i_date[5:0];
        if (c_date) nxt.mon = (cnt.mon == 5'h12) ? 5'h01 : i_mon[4:0];
        if (c_mon) nxt.yr   = (cnt.yr == 8'h99) ? 8'h00 : i_yr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= TK_RESET;
        else if (load)  cnt <= load_val;
        else if (step)  cnt <= nxt;
    end
endmodule

// File: rtl/tk_ctrl.sv
module tk_ctrl
    import tk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_wr,
    input  logic      w_bit,
    input  logic      r_bit,
    input  logic      r_held,
    output tk_state_e st,
    output logic      copy_en,
    output logic      load
);
    tk_state_e st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_RUN, ST_RDHALT: begin
                if (ctrl_wr) st_nx = w_bit ? ST_WRHALT : (r_bit ? ST_RDHALT : ST_RUN);
            end
            ST_WRHALT: begin
                if (ctrl_wr && !w_bit) st_nx = ST_XFER;
            end
            ST_XFER: st_nx = r_held ? ST_RDHALT : ST_RUN;
        endcase
    end

    always_comb begin
        copy_en = (st == ST_RUN);
        load    = (st == ST_XFER);
    end
endmodule

// File: rtl/tk_regbank.sv
module tk_regbank
    import tk_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter logic [ADDR_W-1:0] BASE = 13'h1FF8,
    parameter int unsigned NREG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam int unsigned OFS_W = $clog2(NREG);

    tk_time_t         cnt, vis;
    tk_state_e        st;
    logic             copy_en, load, step, upd_pend, stop_q;
    logic [7:0]       ctrl_q, rd_mux;
    logic             in_win, wr_hit, ctrl_wr;
    logic [OFS_W-1:0] ofs;

    assign in_win  = (bus_addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);
    assign ofs     = bus_addr[OFS_W-1:0];
    assign wr_hit  = bus_wr && in_win;
    assign ctrl_wr = wr_hit && (ofs == '0);
    assign step    = tick_1hz && !stop_q;

    tk_counters u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step), .load(load),
        .load_val(vis), .cnt(cnt)
    );

    tk_ctrl u_ctl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .w_bit(bus_wdata[7]), .r_bit(bus_wdata[6]), .r_held(ctrl_q[6]),
        .st(st), .copy_en(copy_en), .load(load)
    );

    // copy decision is latched at the tick, so a halt in that cycle cannot cancel it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_pend <= 1'b0;
        else        upd_pend <= step && copy_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 8'h00;
            stop_q <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= bus_wdata;
            if (wr_hit && ofs == OFS_W'(1)) stop_q <= bus_wdata[7];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vis <= TK_RESET;
        end else if (upd_pend) begin
            vis <= cnt;
        end else if (wr_hit) begin
            case (ofs)
                OFS_W'(1): vis.sec  <= bus_wdata[6:0];
                OFS_W'(2): vis.mn   <= bus_wdata[6:0];
                OFS_W'(3): vis.hr   <= bus_wdata[5:0];
                OFS_W'(4): vis.dow  <= bus_wdata[2:0];
                OFS_W'(5): vis.date <= bus_wdata[5:0];
                OFS_W'(6): vis.mon  <= bus_wdata[4:0];
                OFS_W'(7): vis.yr   <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (ofs)
            OFS_W'(0): rd_mux = ctrl_q;
            OFS_W'(1): rd_mux = {stop_q, vis.sec};
            OFS_W'(2): rd_mux = {1'b0, vis.mn};
            OFS_W'(3): rd_mux = {2'b0, vis.hr};
            OFS_W'(4): rd_mux = {5'b0, vis.dow};
            OFS_W'(5): rd_mux = {2'b0, vis.date};
            OFS_W'(6): rd_mux = {3'b0, vis.mon};
            default:   rd_mux = vis.yr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= 8'h00;
        else if (bus_rd) bus_rdata <= in_win ? rd_mux : 8'h00;
    end
endmodule

// File: rtl/tk_chk.sv
module tk_chk
    import tk_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input tk_state_e st,
    input logic      upd_pend,
    input logic      stop_q,
    input logic      bus_wr,
    input tk_time_t  cnt,
    input tk_time_t  vis
);
    a_r6_copy_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pend |=> (vis == $past(cnt)));

    a_r7_halt_freezes_view: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RDHALT || st == ST_WRHALT) && !upd_pend && !bus_wr) |=> $stable(vis));

    a_r9_xfer_loads_counters: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER) |=> (cnt == $past(vis)));

    a_r9_xfer_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER) |=> (st != ST_XFER));

    a_r10_stop_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && st != ST_XFER) |=> $stable(cnt));
endmodule

bind tk_regbank tk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .upd_pend(upd_pend),
    .stop_q(stop_q), .bus_wr(bus_wr), .cnt(cnt), .vis(vis)
);

// File: tb/sim_tk_regbank.sv
`timescale 1ns/1ps
module sim_tk_regbank;
    localparam int ADDR_W = 13;
    localparam logic [ADDR_W-1:0] B = 13'h1FF8;

    logic clk = 0, rst_n = 0, tick_1hz = 0, bus_wr = 0, bus_rd = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic rd_seen = 0;
    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    tk_regbank #(.ADDR_W(ADDR_W), .BASE(B)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: pops the expected item for each completed read
    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: unexpected read data %02h", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string t);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic tick();
        @(negedge clk); tick_1hz = 1;
        @(negedge clk); tick_1hz = 0;
        @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo, y);
        wr(B, 8'h80);
        wr(B + 1, s); wr(B + 2, mi); wr(B + 3, h); wr(B + 4, dw);
        wr(B + 5, dt); wr(B + 6, mo); wr(B + 7, y);
        wr(B, 8'h00);
    endtask

    task automatic chk_time(input logic [7:0] s, mi, h, dw, dt, mo, y, input string t);
        rd(B + 1, s, t); rd(B + 2, mi, t); rd(B + 3, h, t); rd(B + 4, dw, t);
        rd(B + 5, dt, t); rd(B + 6, mo, t); rd(B + 7, y, t);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(B, 8'h00, "R1 control");
        chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 time");
        // R2 outside window reads zero
        rd(13'h1FF0, 8'h00, "R2 outside window");
        // R6 plain tick copies
        tick();
        rd(B + 1, 8'h01, "R6 copy after tick");
        // R9 transfer, then R4 Feb non-leap end
        set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
        chk_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23, "R9 loaded view");
        tick();
        rd(B + 1, 8'h59, "R9 counts from loaded");
        tick();
        chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h03, 8'h23, "R4 feb 28 non-leap / R3 dow wrap");
        // R4 leap year
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        tick();
        chk_time(8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 8'h24, "R4 leap feb 29");
        set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
        tick();
        chk_time(8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h03, 8'h24, "R4 leap feb end");
        // R4 30 and 31 day months
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h25);
        tick();
        chk_time(8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 8'h25, "R4 april 30");
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h05, 8'h25);
        tick();
        chk_time(8'h00, 8'h00, 8'h00, 8'h03, 8'h31, 8'h05, 8'h25, "R4 may 31");
        // R5 year wrap
        set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
        tick();
        chk_time(8'h00, 8'h00, 8'h00, 8'h07, 8'h01, 8'h01, 8'h00, "R5 year 99 to 00");
        // R3 BCD digit carry in hours
        set_time(8'h59, 8'h59, 8'h09, 8'h01, 8'h15, 8'h06, 8'h30);
        tick();
        chk_time(8'h00, 8'h00, 8'h10, 8'h01, 8'h15, 8'h06, 8'h30, "R3 hour 09 to 10");
        // R7 read halt
        set_time(8'h10, 8'h20, 8'h05, 8'h02, 8'h10, 8'h07, 8'h30);
        wr(B, 8'h40);
        tick(); tick(); tick();
        rd(B + 1, 8'h10, "R7 view frozen");
        rd(B, 8'h40, "R7 control readback");
        wr(B, 8'h00);
        rd(B + 1, 8'h10, "R7 unchanged until tick");
        tick();
        rd(B + 1, 8'h14, "R7 counters ran during halt");
        // R8 halt in the tick cycle
        @(negedge clk); tick_1hz = 1; bus_wr = 1; bus_addr = B; bus_wdata = 8'h40;
        @(negedge clk); tick_1hz = 0; bus_wr = 0;
        @(negedge clk);
        rd(B + 1, 8'h15, "R8 copy completes");
        tick();
        rd(B + 1, 8'h15, "R8 halted afterwards");
        wr(B, 8'h00);
        tick();
        rd(B + 1, 8'h17, "R8 resume");
        // R10 stop bit without halt
        wr(B + 1, 8'h97);
        tick(); tick();
        rd(B + 1, 8'h97, "R10 stopped");
        wr(B + 1, 8'h17);
        tick();
        rd(B + 1, 8'h18, "R10 restarted");
        // R9 write halt keeps user values
        wr(B, 8'h80);
        wr(B + 2, 8'h45);
        tick();
        rd(B + 2, 8'h45, "R9 user minute kept");
        rd(B + 1, 8'h18, "R9 seconds not refreshed");
        wr(B, 8'h00);
        tick();
        rd(B + 2, 8'h45, "R9 transferred minute");
        rd(B + 1, 8'h19, "R9 transferred seconds");
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule